// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus on which a target has been left holding SDA low, for example after a transfer was cut off mid-byte. When recovery is requested, it takes both bus lines away from the normal I2C engine and holds that engine disabled, so the engine cannot latch a bus-busy condition that never clears. It then drives the lines itself through open-drain style pull-down outputs.

With both lines released, the block waits one half bit period and samples SDA. If SDA is low, it clocks SCL: low for one half period, then released for one half period. SDA is sampled at the end of every released phase. Clocking stops as soon as SDA reads high, or once the pulse limit is reached. If at least one pulse was issued, the block then creates a START followed by a STOP while SCL stays released.

Finally it hands the lines back, re-enables the engine and signals completion with a one-cycle done pulse. A flag travels with the done pulse and reports whether SDA was still stuck. The half period is a count of system clock cycles, so the default of 625 cycles at 125 MHz gives the 5 µs half period of a 100 kHz bus. SCL and SDA are read through synchronizer stages. A released SCL phase starts timing only once SCL reads high, so a target that stretches the clock lengthens that phase.

Top module: `bus_unjam_seq`

## Requirements
- R1: After reset, engine_en_o is 1, pin_own_o is 0, scl_pull_o, sda_pull_o, done_o and stuck_o are 0.
- R2: While pin_own_o is 1, engine_en_o is 0. In the cycle done_o is 1, pin_own_o is 0 and engine_en_o is 1.
- R3: After a request, both pull outputs stay 0 (line released) for HALF_CYCLES cycles. If SDA then samples high, no SCL pulse and no START/STOP is produced, and stuck_o is 0.
- R4: A pull output of 1 means the line is pulled low, and 0 means it is released. Each SCL pulse holds scl_pull_o at 1 for exactly HALF_CYCLES cycles. The released phase lasts HALF_CYCLES cycles, counted from the cycle SCL reads high through its SYNC_STAGES synchronizer.
- R5: SDA is sampled at the end of each released SCL phase, and clocking stops at the first sample that reads high. The pulse count then equals the number of SCL pulses the target needed before releasing SDA.
- R6: At most MAX_PULSES SCL pulses are issued. stuck_o is 1 with done_o exactly when SDA still reads low at the end of the last allowed pulse.
- R7: If at least one pulse was issued, sda_pull_o is 1 for exactly HALF_CYCLES cycles while scl_pull_o is 0, then 0 for HALF_CYCLES cycles before done. Exactly one such START/STOP pair is produced.
- R8: done_o is high for one cycle. For P pulses, the request edge E and the done edge D satisfy D − E = H + P·(2H + S) + (P>0 ? 2H : 0), where H = HALF_CYCLES and S = SYNC_STAGES.
- R9: A request that arrives while a recovery is running has no effect on that recovery's timing or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req_i | input | 1 | Recovery request, accepted when idle |
| scl_i | input | 1 | SCL line level as read from the pad |
| sda_i | input | 1 | SDA line level as read from the pad |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| pin_own_o | output | 1 | 1 routes both pads to this block instead of the engine |
| engine_en_o | output | 1 | Enable for the main I2C controller |
| done_o | output | 1 | One-cycle completion pulse |
| stuck_o | output | 1 | With done_o: SDA still low after the final pulse |

## Verification
The done pulse is due D − E cycles after the edge that captures the request, computed from R8 with the pulse count the bench derives from how many SCL pulses its simulated target needs. The bench therefore counts falling clock edges from the capturing edge and compares the count at the first observed done against that value. Pull outputs change at a clock edge and are sampled at the following falling edge. Pulse widths are measured as runs of consecutive falling-edge samples and must equal HALF_CYCLES. Pulse counts, the START/STOP count and stuck_o are collected over each run and compared in the done cycle, and the handback is checked in that same cycle and one cycle later.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PREP   = 3'd1,
      ST_SCL_LO = 3'd2,
      ST_SCL_HI = 3'd3,
      ST_SDA_LO = 3'd4,
      ST_SDA_HI = 3'd5,
      ST_DONE   = 3'd6
   } unjam_state_e;

   localparam int unsigned LINE_COUNT = 2;
   localparam int unsigned LINE_SCL   = 0;
   localparam int unsigned LINE_SDA   = 1;

   function automatic logic is_timed(unjam_state_e s);
      return (s != ST_IDLE) && (s != ST_DONE);
   endfunction

   function automatic logic owns_lines(unjam_state_e s);
      return (s != ST_IDLE) && (s != ST_DONE);
   endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("unjam_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= RESET_VAL;
            else        q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] sh_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_r <= {STAGES{RESET_VAL}};
            else        sh_r <= {sh_r[STAGES-2:0], d_i};
         end
         assign q_o = sh_r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/unjam_halftimer.sv
module unjam_halftimer #(
   parameter int unsigned HALF_CYCLES = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);

   localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

   generate
      if (HALF_CYCLES < 2) begin : g_bad_half
         $error("unjam_halftimer: HALF_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_r;

   assign expire_o = run_i && (cnt_r == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_r <= '0;
      else if (!run_i)       cnt_r <= '0;
      else if (cnt_r == LAST) cnt_r <= '0;
      else                   cnt_r <= cnt_r + 1'b1;
   end

endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl
   import bus_unjam_pkg::*;
#(
   parameter int unsigned MAX_PULSES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic expire_i,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic run_o,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic own_o,
   output logic engine_en_o,
   output logic done_o,
   output logic stuck_o
);

   localparam int unsigned PC_W = $clog2(MAX_PULSES + 1);
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(MAX_PULSES - 1);

   generate
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("unjam_ctrl: MAX_PULSES must be at least 1");
      end
   endgenerate

   unjam_state_e     state_r, state_n;
   logic [PC_W-1:0]  pulses_r;
   logic             stuck_r;
   logic             last_pulse;
   logic             hi_end;

   assign last_pulse = (pulses_r == PC_LAST);
   assign hi_end     = (state_r == ST_SCL_HI) && expire_i;

   // a released SCL phase is timed only once SCL reads high (stretch tolerant)
   assign run_o = is_timed(state_r) && !((state_r == ST_SCL_HI) && !scl_s_i);

   always_comb begin
      state_n = state_r;
      unique case (state_r)
         ST_IDLE:   if (req_i)    state_n = ST_PREP;
         ST_PREP:   if (expire_i) state_n = sda_s_i ? ST_DONE : ST_SCL_LO;
         ST_SCL_LO: if (expire_i) state_n = ST_SCL_HI;
         ST_SCL_HI: if (expire_i) state_n = (sda_s_i || last_pulse) ? ST_SDA_LO : ST_SCL_LO;
         ST_SDA_LO: if (expire_i) state_n = ST_SDA_HI;
         ST_SDA_HI: if (expire_i) state_n = ST_DONE;
         ST_DONE:                 state_n = ST_IDLE;
         default:                 state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_r  <= ST_IDLE;
         pulses_r <= '0;
         stuck_r  <= 1'b0;
      end else begin
         state_r <= state_n;
         if (state_r == ST_IDLE) begin
            pulses_r <= '0;
            if (req_i) stuck_r <= 1'b0;
         end else if (hi_end) begin
            pulses_r <= pulses_r + 1'b1;
            stuck_r  <= !sda_s_i && last_pulse;
         end
      end
   end

   assign scl_pull_o  = (state_r == ST_SCL_LO);
   assign sda_pull_o  = (state_r == ST_SDA_LO);
   assign own_o       = owns_lines(state_r);
   assign engine_en_o = !owns_lines(state_r);
   assign done_o      = (state_r == ST_DONE);
   assign stuck_o     = (state_r == ST_DONE) && stuck_r;

endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq
   import bus_unjam_pkg::*;
#(
   parameter int unsigned HALF_CYCLES = 625,
   parameter int unsigned MAX_PULSES  = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic recover_req_i,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_pull_o,
   output logic sda_pull_o,
   output logic pin_own_o,
   output logic engine_en_o,
   output logic done_o,
   output logic stuck_o
);

   logic [LINE_COUNT-1:0] line_raw;
   logic [LINE_COUNT-1:0] line_s;
   logic                  run;
   logic                  expire;

   assign line_raw[LINE_SCL] = scl_i;
   assign line_raw[LINE_SDA] = sda_i;

   generate
      for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line_sync
         unjam_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
         ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (line_raw[i]),
            .q_o  (line_s[i])
         );
      end
   endgenerate

   unjam_halftimer #(
      .HALF_CYCLES(HALF_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .expire_o(expire)
   );

   unjam_ctrl #(
      .MAX_PULSES(MAX_PULSES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (recover_req_i),
      .expire_i   (expire),
      .scl_s_i    (line_s[LINE_SCL]),
      .sda_s_i    (line_s[LINE_SDA]),
      .run_o      (run),
      .scl_pull_o (scl_pull_o),
      .sda_pull_o (sda_pull_o),
      .own_o      (pin_own_o),
      .engine_en_o(engine_en_o),
      .done_o     (done_o),
      .stuck_o    (stuck_o)
   );

endmodule

// File: rtl/bus_unjam_chk.sv
module bus_unjam_chk (
   input logic clk,
   input logic rst_n,
   input logic recover_req_i,
   input logic scl_pull_o,
   input logic sda_pull_o,
   input logic pin_own_o,
   input logic engine_en_o,
   input logic done_o,
   input logic stuck_o
);

   // R2
   own_disables_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_own_o |-> !engine_en_o);

   // R2
   done_hands_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!pin_own_o && engine_en_o));

   // R7
   start_with_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> !scl_pull_o);

   // R4
   scl_pull_only_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pull_o || sda_pull_o) |-> pin_own_o);

   // R8
   done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   stuck_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_o |-> done_o);

   // R9
   takeover_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_own_o && !recover_req_i) |=> !pin_own_o);

endmodule

bind bus_unjam_seq bus_unjam_chk u_bus_unjam_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .recover_req_i(recover_req_i),
   .scl_pull_o   (scl_pull_o),
   .sda_pull_o   (sda_pull_o),
   .pin_own_o    (pin_own_o),
   .engine_en_o  (engine_en_o),
   .done_o       (done_o),
   .stuck_o      (stuck_o)
);

// File: tb/test_bus_unjam_seq.sv
module test_bus_unjam_seq;

   localparam int H   = 6;
   localparam int MAXP = 9;
   localparam int S   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic scl_pull, sda_pull, own, eng_en, done, stuck;
   logic scl_bus, sda_bus;
   int   hold_left = 0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   assign scl_bus = ~scl_pull;
   assign sda_bus = ~(sda_pull | (hold_left > 0));

   // stuck target: releases SDA after seeing hold_left SCL rising edges
   always @(posedge scl_bus) if (hold_left > 0) hold_left = hold_left - 1;

   bus_unjam_seq #(.HALF_CYCLES(H), .MAX_PULSES(MAXP), .SYNC_STAGES(S)) i_bus_unjam_seq (
      .clk(clk), .rst_n(rst_n), .recover_req_i(req),
      .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .pin_own_o(own),
      .engine_en_o(eng_en), .done_o(done), .stuck_o(stuck));

   // monitors sampled at falling edges
   int  scl_pulses, sda_pulses, own_viol, order_viol, width_viol;
   int  scl_run, sda_run;
   logic scl_prev = 1'b0, sda_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (own && eng_en) own_viol++;
         if (sda_pull && scl_pull) order_viol++;
         if (scl_pull && !scl_prev) scl_pulses++;
         if (sda_pull && !sda_prev) sda_pulses++;
         if (scl_pull) scl_run++;
         else begin
            if (scl_prev && scl_run != H) width_viol++;
            scl_run = 0;
         end
         if (sda_pull) sda_run++;
         else begin
            if (sda_prev && sda_run != H) width_viol++;
            sda_run = 0;
         end
         scl_prev = scl_pull;
         sda_prev = sda_pull;
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_pulses(int k);
      if (k == 0) return 0;
      return (k > MAXP) ? MAXP : k;
   endfunction

   function automatic int exp_latency(int p);
      return H + p * (2 * H + S) + ((p > 0) ? 2 * H : 0) + 1;
   endfunction

   task automatic run_case(int k, bit disturb);
      int cyc;
      int p;
      p = exp_pulses(k);
      hold_left = k;
      repeat (4) @(negedge clk);
      scl_pulses = 0; sda_pulses = 0; own_viol = 0; order_viol = 0; width_viol = 0;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      cyc = 1;
      while (!done && cyc < 5000) begin
         req = (disturb && cyc == 10);
         @(negedge clk);
         cyc++;
      end
      req = 1'b0;
      check("R8 latency", cyc, exp_latency(p));
      check("R5 R6 scl pulse count", scl_pulses, p);
      check("R7 start/stop count", sda_pulses, (p > 0) ? 1 : 0);
      check("R6 stuck flag", int'(stuck), (k > MAXP) ? 1 : 0);
      check("R2 handback own", int'(own), 0);
      check("R2 handback engine", int'(eng_en), 1);
      check("R2 engine off while owned", own_viol, 0);
      check("R7 sda low only with scl high", order_viol, 0);
      check("R4 R7 pulse width", width_viol, 0);
      if (k == 0) check("R3 no activity when sda high", scl_pulses + sda_pulses, 0);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
      hold_left = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 reset engine_en", int'(eng_en), 1);
      check("R1 reset own", int'(own), 0);
      check("R1 reset pulls", int'(scl_pull | sda_pull), 0);
      check("R1 reset done/stuck", int'(done | stuck), 0);
      // directed corners
      run_case(0, 1'b0);      // R3
      run_case(1, 1'b0);      // R5
      run_case(MAXP, 1'b0);   // R6 boundary: released on last pulse
      run_case(MAXP + 1, 1'b0); // R6 stuck
      run_case(1000, 1'b0);   // R6 permanently stuck
      run_case(4, 1'b1);      // R9 request while busy
      run_case(0, 1'b1);      // R9
      for (int i = 0; i < 14; i++) begin
         k = int'($urandom % 13);
         run_case(k, ($urandom % 2) == 1);
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule